// File: doc/BRIEF.md
# Macro Sequencer with Delay Slots

The block is the control core of a small macro engine. On a start pulse it begins fetching 32-bit instruction words from an external instruction memory at a given word offset. It holds eight 32-bit working registers and runs one instruction per cycle. The arithmetic, bitfield and host-register-read operations feed a result-routing stage. That stage can write a destination register, pull the next word from a parameter FIFO, load a method-address register, and emit method writes (address plus data) to the host engine over a valid/ready channel.

Control flow uses delayed branches: a taken branch runs the instruction after it before jumping, unless the branch is annulled. An exit marker ends the macro only after one more instruction has run. When the core stops it pulses `done_o`. `error_o` reports an illegal operation, a branch placed in a delay slot, or parameters that the macro left unread. The instruction memory and the host register file are read combinationally through the address outputs.

Top module: `macro_seq`

## Requirements
- R1: Instruction fields: operation [2:0] (0 ALU, 1 add-immediate, 2 insert, 3 extract-shift by immediate, 4 extract-shift by register, 5 host read, 6 illegal, 7 branch), routing [6:4], exit [7], destination [10:8], source A [13:11], source B [16:14], signed immediate [31:14], ALU select / source bit [21:17], field size [26:22], destination bit [31:27].
- R2: Out of reset the core is idle, with done, error, write-valid and parameter-ready low. A start pulse sets the fetch address to the start offset, clears all registers, the carry and the method register, and loads the first parameter into register 1.
- R3: Register 0 reads as zero, and writes to it have no effect.
- R4: ALU select codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 8 xor, 9 or, 10 and, 11 A and not B, 12 nand. Add sets carry on 32-bit overflow. Subtract sets carry when no borrow occurs. Subtract with borrow takes one extra away when carry is clear.
- R5: Add-immediate returns A plus the sign-extended immediate. Host read drives the host address A plus the immediate and returns the host data.
- R6: Bitfield ops use mask = 2^size-1. Insert puts (B>>srcbit)&mask into A at dstbit. Extract-shift by immediate returns ((B>>A)&mask)<<dstbit. Extract-shift by register returns ((B>>srcbit)&mask)<<A.
- R7: Routing: 0 fetch to dst; 1 move; 2 move and set method; 3 fetch to dst and send result; 4 move and send; 5 fetch to dst and set method from result; 6 move, set method, send fetched parameter; 7 move, set method, send result bits [17:12].
- R8: The method register holds an address in bits [11:0] and a step in bits [17:12]. A send uses the current address (set in the same instruction for routings 6 and 7), then adds the step, wrapping within 12 bits.
- R9: A branch tests A for zero (bit 4 = 0) or nonzero (bit 4 = 1). The target word is the branch's own address plus the immediate. If taken, the next instruction runs first, unless annul bit 5 is set, in which case the jump is direct. An untaken branch falls through.
- R10: An exit bit outside a delay slot runs one more instruction and then stops with a one-cycle done pulse. An exit bit inside a delay slot has no effect.
- R11: An instruction that needs a parameter while the FIFO is empty, or sends while write-ready is low, stalls without state change while holding write address and data stable. Parameters are popped only when valid.
- R12: Operation 6, or a branch in a delay slot, halts with done and error. Error is also raised if parameters remain unread when the macro stops. It stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken while idle |
| start_offset_i | input | IMEM_AW | Word address of the first instruction |
| imem_addr_o | output | IMEM_AW | Instruction memory word address |
| imem_data_i | input | 32 | Instruction word at imem_addr_o |
| param_valid_i | input | 1 | Parameter FIFO not empty |
| param_data_i | input | 32 | Parameter FIFO head |
| param_ready_o | output | 1 | Pop parameter FIFO |
| mw_valid_o | output | 1 | Method write valid |
| mw_ready_i | input | 1 | Method write ready |
| mw_addr_o | output | MADDR_W | Method write address |
| mw_data_o | output | 32 | Method write data |
| hr_addr_o | output | 32 | Host register read address |
| hr_data_i | input | 32 | Host register read data |
| done_o | output | 1 | Macro finished (one-cycle pulse) |
| error_o | output | 1 | Error flag |

## Verification
The arithmetic and bitfield paths run from a table of operand pairs. Each pair is picked so that a wrong select code, a wrong field position or a wrong carry sense gives a visibly different sent value. A loop counter with a delayed backward branch tells delay-slot execution apart from annulled skipping and from fall-through. A second program walks every routing mode under write backpressure and a starved FIFO, which separates send-before-step from step-before-send, and shows the 12-bit address wrap. Short faulty programs then exercise each error cause, and a later clean run shows the flag cleared.

// File: rtl/macro_seq_pkg.sv
package macro_seq_pkg;
  localparam logic [2:0] OP_ALU    = 3'd0;
  localparam logic [2:0] OP_ADDI   = 3'd1;
  localparam logic [2:0] OP_INS    = 3'd2;
  localparam logic [2:0] OP_EXT_SI = 3'd3;
  localparam logic [2:0] OP_EXT_SR = 3'd4;
  localparam logic [2:0] OP_READ   = 3'd5;
  localparam logic [2:0] OP_BAD    = 3'd6;
  localparam logic [2:0] OP_BR     = 3'd7;

  localparam logic [4:0] AL_ADD  = 5'd0;
  localparam logic [4:0] AL_ADC  = 5'd1;
  localparam logic [4:0] AL_SUB  = 5'd2;
  localparam logic [4:0] AL_SBB  = 5'd3;
  localparam logic [4:0] AL_XOR  = 5'd8;
  localparam logic [4:0] AL_OR   = 5'd9;
  localparam logic [4:0] AL_AND  = 5'd10;
  localparam logic [4:0] AL_ANDN = 5'd11;
  localparam logic [4:0] AL_NAND = 5'd12;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_FIN} state_e;
endpackage

// File: rtl/macro_alu.sv
module macro_alu
  import macro_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [4:0]    sel_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o,
  output logic          cupd_o
);
  logic [DW:0] wide;

  always_comb begin
    wide   = '0;
    res_o  = '0;
    cout_o = 1'b0;
    cupd_o = 1'b0;
    unique case (sel_i)
      AL_ADD, AL_ADC: begin
        wide   = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, (sel_i == AL_ADC) & cin_i};
        res_o  = wide[DW-1:0];
        cout_o = wide[DW];
        cupd_o = 1'b1;
      end
      AL_SUB, AL_SBB: begin
        wide   = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, (sel_i == AL_SBB) & ~cin_i};
        res_o  = wide[DW-1:0];
        cout_o = ~wide[DW];  // set when no borrow
        cupd_o = 1'b1;
      end
      AL_XOR:  res_o = a_i ^ b_i;
      AL_OR:   res_o = a_i | b_i;
      AL_AND:  res_o = a_i & b_i;
      AL_ANDN: res_o = a_i & ~b_i;
      AL_NAND: res_o = ~(a_i & b_i);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/macro_bitfield.sv
module macro_bitfield
  import macro_seq_pkg::*;
#(
  parameter int DW = 32,
  localparam int SW = $clog2(DW)
) (
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [SW-1:0] src_bit_i,
  input  logic [SW-1:0] size_i,
  input  logic [SW-1:0] dst_bit_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] mask, fld_src;

  always_comb begin
    mask    = ({{(DW-1){1'b0}}, 1'b1} << size_i) - 1'b1;
    fld_src = (b_i >> src_bit_i) & mask;
    unique case (op_i)
      OP_INS:    res_o = (a_i & ~(mask << dst_bit_i)) | (fld_src << dst_bit_i);
      OP_EXT_SI: res_o = ((b_i >> a_i) & mask) << dst_bit_i;
      OP_EXT_SR: res_o = fld_src << a_i;
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/macro_regfile.sv
module macro_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_a_i,
  input  logic [IW-1:0] ridx_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            regs[i] <= '0;
        else if (we_i && widx_i == IW'(i))      regs[i] <= wdata_i;
        else if (clr_i)                         regs[i] <= '0;
      end
    end
  end

  assign rdata_a_o = regs[ridx_a_i];
  assign rdata_b_o = regs[ridx_b_i];
endmodule

// File: rtl/macro_seq.sv
module macro_seq
  import macro_seq_pkg::*;
#(
  parameter int IMEM_AW = 10,
  parameter int MADDR_W = 12,
  parameter int MSTEP_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [IMEM_AW-1:0] start_offset_i,
  output logic [IMEM_AW-1:0] imem_addr_o,
  input  logic [31:0]        imem_data_i,
  input  logic               param_valid_i,
  input  logic [31:0]        param_data_i,
  output logic               param_ready_o,
  output logic               mw_valid_o,
  input  logic               mw_ready_i,
  output logic [MADDR_W-1:0] mw_addr_o,
  output logic [31:0]        mw_data_o,
  output logic [31:0]        hr_addr_o,
  input  logic [31:0]        hr_data_i,
  output logic               done_o,
  output logic               error_o
);
  localparam int DW   = 32;
  localparam int NREG = 8;
  localparam int MW   = MADDR_W + MSTEP_W;

  state_e             state_q;
  logic [IMEM_AW-1:0] pc_q, tgt_q, br_tgt;
  logic               slot_q, exit_pend_q, carry_q, err_q;
  logic [MW-1:0]      maddr_q, ma_cur;

  // decode
  logic [2:0]  op, rop, dst, sra, srb;
  logic [4:0]  sel;
  logic [31:0] imm, ra, rb, result, alu_res, bf_res;
  logic        exit_b, annul, alu_cout, alu_cupd;
  assign op     = imem_data_i[2:0];
  assign rop    = imem_data_i[6:4];
  assign exit_b = imem_data_i[7];
  assign dst    = imem_data_i[10:8];
  assign sra    = imem_data_i[13:11];
  assign srb    = imem_data_i[16:14];
  assign sel    = imem_data_i[21:17];
  assign annul  = imem_data_i[5];
  assign imm    = {{14{imem_data_i[31]}}, imem_data_i[31:14]};

  logic run, is_exec, need_param, wr_param, need_send, setm, param_ok, send_ok, fire, taken;
  logic rf_we, rf_clr;
  logic [2:0]  rf_widx;
  logic [31:0] rf_wdata;

  assign run        = (state_q == S_RUN);
  assign is_exec    = (op != OP_BR) && (op != OP_BAD);
  assign wr_param   = (rop == 3'd0) || (rop == 3'd3) || (rop == 3'd5);
  assign need_param = wr_param || (rop == 3'd6);
  assign need_send  = (rop == 3'd3) || (rop == 3'd4) || (rop == 3'd6) || (rop == 3'd7);
  assign setm       = (rop == 3'd2) || (rop >= 3'd5);
  assign param_ok   = !need_param || param_valid_i;
  assign send_ok    = !need_send || mw_ready_i;
  assign fire       = run && (!is_exec || (param_ok && send_ok));
  assign taken      = rop[0] ? (ra != '0) : (ra == '0);
  assign br_tgt     = pc_q + imm[IMEM_AW-1:0];

  macro_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i, .rst_ni,
    .clr_i(rf_clr), .we_i(rf_we), .widx_i(rf_widx), .wdata_i(rf_wdata),
    .ridx_a_i(sra), .ridx_b_i(srb), .rdata_a_o(ra), .rdata_b_o(rb)
  );

  macro_alu #(.DW(DW)) u_alu (
    .sel_i(sel), .a_i(ra), .b_i(rb), .cin_i(carry_q),
    .res_o(alu_res), .cout_o(alu_cout), .cupd_o(alu_cupd)
  );

  macro_bitfield #(.DW(DW)) u_bf (
    .op_i(op), .a_i(ra), .b_i(rb),
    .src_bit_i(imem_data_i[21:17]), .size_i(imem_data_i[26:22]), .dst_bit_i(imem_data_i[31:27]),
    .res_o(bf_res)
  );

  assign hr_addr_o = ra + imm;

  always_comb begin
    unique case (op)
      OP_ALU:                     result = alu_res;
      OP_ADDI:                    result = ra + imm;
      OP_INS, OP_EXT_SI, OP_EXT_SR: result = bf_res;
      OP_READ:                    result = hr_data_i;
      default:                    result = '0;
    endcase
  end

  assign rf_clr   = (state_q == S_LOAD);
  assign rf_we    = (state_q == S_LOAD) ? param_valid_i : (fire && is_exec);
  assign rf_widx  = (state_q == S_LOAD) ? 3'd1 : dst;
  assign rf_wdata = ((state_q == S_LOAD) || wr_param) ? param_data_i : result;

  assign ma_cur        = setm ? result[MW-1:0] : maddr_q;
  assign mw_valid_o    = run && is_exec && need_send && param_ok;
  assign mw_addr_o     = ma_cur[MADDR_W-1:0];
  assign mw_data_o     = (rop == 3'd6) ? param_data_i :
                         (rop == 3'd7) ? 32'(result[MADDR_W +: MSTEP_W]) : result;
  assign param_ready_o = ((state_q == S_LOAD) && param_valid_i) ||
                         (run && is_exec && need_param && param_valid_i && send_ok);
  assign imem_addr_o   = pc_q;
  assign done_o        = (state_q == S_FIN);
  assign error_o       = err_q || (done_o && param_valid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;  pc_q <= '0;  tgt_q <= '0;  slot_q <= 1'b0;
      exit_pend_q <= 1'b0;  carry_q <= 1'b0;  err_q <= 1'b0;  maddr_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_LOAD;  pc_q <= start_offset_i;  slot_q <= 1'b0;
          exit_pend_q <= 1'b0;  carry_q <= 1'b0;  err_q <= 1'b0;  maddr_q <= '0;
        end
        S_LOAD: if (param_valid_i) state_q <= S_RUN;
        S_RUN: if (fire) begin
          if (is_exec) begin
            if (op == OP_ALU && alu_cupd) carry_q <= alu_cout;
            if (need_send)
              maddr_q <= {ma_cur[MW-1:MADDR_W],
                          ma_cur[MADDR_W-1:0] + MADDR_W'(ma_cur[MW-1:MADDR_W])};
            else if (setm)
              maddr_q <= result[MW-1:0];
          end
          if (op == OP_BAD || (op == OP_BR && slot_q)) begin
            err_q   <= 1'b1;
            state_q <= S_FIN;
          end else if (slot_q) begin
            slot_q <= 1'b0;
            if (exit_pend_q) state_q <= S_FIN;
            else             pc_q    <= tgt_q;
          end else if (op == OP_BR && taken) begin
            if (annul) pc_q <= br_tgt;
            else begin
              pc_q <= pc_q + 1'b1;  slot_q <= 1'b1;  tgt_q <= br_tgt;
            end
          end else begin
            pc_q <= pc_q + 1'b1;
            if (exit_b) begin
              slot_q <= 1'b1;  exit_pend_q <= 1'b1;
            end
          end
        end
        S_FIN: begin
          err_q   <= error_o;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_r0_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && sra == 3'd0) |-> (ra == '0));
  assert_send_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mw_valid_o && !mw_ready_i) |=> (mw_valid_o && $stable(mw_addr_o) && $stable(mw_data_o)));
  assert_pop_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    param_ready_o |-> param_valid_i);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_annul_jump_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op == OP_BR && !slot_q && taken && annul) |=> (imem_addr_o == $past(br_tgt)));
  assert_bad_op_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && op == OP_BAD) |=> (done_o && error_o));
  assert_start_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i) |=> (imem_addr_o == $past(start_offset_i) && !error_o));
endmodule

// File: tb/macro_seq_tb.sv
`timescale 1ns/1ps
module macro_seq_tb;
  localparam int AW = 10;
  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [AW-1:0] start_off = '0, imem_addr;
  logic [31:0] imem_data, param_data, mw_data, hr_addr, hr_data;
  logic param_valid, param_ready, mw_valid, mw_ready = 1'b1, done, error;
  logic [11:0] mw_addr;

  always #4 clk = ~clk;

  logic [31:0] imem [1024];
  logic [31:0] pq [16];
  int pcount = 0, pidx = 0;
  logic phold = 1'b0;
  logic [11:0] s_addr [32];
  logic [31:0] s_data [32];
  int scount = 0;
  int checks = 0, fails = 0, cyc = 0;
  logic bp_en = 1'b0;

  assign imem_data   = imem[imem_addr];
  assign param_valid = !phold && (pidx < pcount);
  assign param_data  = pq[pidx[3:0]];
  assign hr_data     = hr_addr ^ 32'h5A5A_0000;

  macro_seq #(.IMEM_AW(AW)) u_dut (
    .clk_i(clk), .rst_ni, .start_i(start), .start_offset_i(start_off),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .param_valid_i(param_valid), .param_data_i(param_data), .param_ready_o(param_ready),
    .mw_valid_o(mw_valid), .mw_ready_i(mw_ready), .mw_addr_o(mw_addr), .mw_data_o(mw_data),
    .hr_addr_o(hr_addr), .hr_data_i(hr_data), .done_o(done), .error_o(error)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (param_ready && param_valid) pidx <= pidx + 1;
    if (mw_valid && mw_ready && scount < 32) begin
      s_addr[scount] <= mw_addr;
      s_data[scount] <= mw_data;
      scount <= scount + 1;
    end
  end

  always @(negedge clk) mw_ready <= !(bp_en && (cyc % 3 == 0));

  function automatic logic [31:0] enc(input logic [2:0] op, input logic [2:0] rop,
      input logic ex, input logic [2:0] dst, input logic [2:0] sa, input logic [17:0] up);
    return {up, sa, dst, ex, rop, 1'b0, op};
  endfunction
  function automatic logic [17:0] alu_up(input logic [4:0] sel, input logic [2:0] sb);
    return {10'b0, sel, sb};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) imem[i] = 32'h0000_0011;  // addi move r0 <- r0
  endtask

  // start a run and wait for done; returns error flag at done
  task automatic run_prog(input logic [AW-1:0] off, output logic err_at_done);
    int t;
    @(negedge clk);
    pidx = 0; scount = 0;
    start_off = off; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(done, "R10 done reached", {31'b0, done}, 32'd1);
    err_at_done = error;
  endtask

  localparam int NV = 13;
  localparam logic [2:0]  V_OP [NV] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0,
                                        3'd2, 3'd3, 3'd4, 3'd1, 3'd5};
  localparam logic [17:0] V_UP [NV] = '{
    {10'b0, 5'd0, 3'd2}, {10'b0, 5'd2, 3'd2}, {10'b0, 5'd8, 3'd2}, {10'b0, 5'd9, 3'd2},
    {10'b0, 5'd10, 3'd2}, {10'b0, 5'd11, 3'd2}, {10'b0, 5'd12, 3'd2}, {10'b0, 5'd3, 3'd2},
    {5'd8, 5'd4, 5'd4, 3'd2}, {5'd4, 5'd8, 5'd0, 3'd2}, {5'd0, 5'd12, 5'd12, 3'd2},
    18'h3FFFD, 18'h00004};
  localparam logic [31:0] V_A [NV] = '{32'd5, 32'd5, 32'hF0F0_1234, 32'h0000_00F0,
    32'hFF00_FF00, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'd10, 32'hFFFF_FFFF, 32'd8, 32'd16,
    32'd100, 32'h10};
  localparam logic [31:0] V_B [NV] = '{32'd7, 32'd7, 32'h0FF0_FFFF, 32'h0000_000F,
    32'h0F0F_0F0F, 32'h0F0F_0F0F, 32'h0000_FFFF, 32'd3, 32'h0000_00AB, 32'h0000_AB00,
    32'h1234_5678, 32'd0, 32'd0};
  localparam logic [31:0] V_X [NV] = '{32'd12, 32'hFFFF_FFFE, 32'hFF00_EDCB, 32'h0000_00FF,
    32'h0F00_0F00, 32'hF0F0_0000, 32'hFFFF_0000, 32'd6, 32'hFFFF_FAFF, 32'h0000_0AB0,
    32'h0345_0000, 32'd97, 32'h5A5A_0014};

  logic e;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(!done && !error && !mw_valid && !param_ready, "R2 reset idle",
        {done, error, mw_valid, param_ready}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R4 R5 R6 vector table
    for (int k = 0; k < NV; k++) begin
      imem[256] = enc(3'd1, 3'd0, 1'b0, 3'd2, 3'd0, 18'd0);
      imem[257] = enc(V_OP[k], 3'd4, 1'b1, 3'd3, 3'd1, V_UP[k]);
      imem[258] = enc(3'd1, 3'd1, 1'b0, 3'd0, 3'd0, 18'd0);
      pq[0] = V_A[k]; pq[1] = V_B[k]; pcount = 2;
      run_prog(10'd256, e);
      chk(scount == 1 && s_data[0] == V_X[k], $sformatf("R1 R4 R5 R6 vector %0d", k),
          s_data[0], V_X[k]);
      chk(!e, "R12 no error on clean vector", {31'b0, e}, 32'd0);
    end

    // R7 R8 R11 routing, method address, backpressure, starved FIFO
    clear_mem();
    imem[16] = enc(3'd1, 3'd2, 1'b0, 3'd3, 3'd1, 18'd0);
    imem[17] = enc(3'd1, 3'd4, 1'b0, 3'd4, 3'd0, 18'd7);
    imem[18] = enc(3'd1, 3'd3, 1'b0, 3'd5, 3'd0, 18'd9);
    imem[19] = enc(3'd0, 3'd4, 1'b0, 3'd6, 3'd5, alu_up(5'd0, 3'd0));
    imem[20] = enc(3'd1, 3'd6, 1'b0, 3'd0, 3'd0, 18'h03020);
    imem[21] = enc(3'd1, 3'd7, 1'b0, 3'd0, 3'd0, 18'h05FFF);
    imem[22] = enc(3'd1, 3'd4, 1'b0, 3'd0, 3'd0, 18'd1);
    imem[23] = enc(3'd1, 3'd5, 1'b0, 3'd2, 3'd0, 18'h01100);
    imem[24] = enc(3'd0, 3'd4, 1'b1, 3'd0, 3'd2, alu_up(5'd0, 3'd0));
    imem[25] = enc(3'd1, 3'd4, 1'b0, 3'd0, 3'd0, 18'd2);
    imem[26] = enc(3'd1, 3'd4, 1'b0, 3'd0, 3'd0, 18'd3);
    pq[0] = 32'h2005; pq[1] = 32'hAAAA; pq[2] = 32'hBBBB; pq[3] = 32'hCCCC; pcount = 4;
    bp_en = 1'b1; phold = 1'b1;
    @(negedge clk);
    pidx = 0; scount = 0; start_off = 10'd16; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk(!param_ready && !mw_valid && !done, "R11 stall on empty FIFO",
          {param_ready, mw_valid, done}, 32'd0);
      @(negedge clk);
    end
    phold = 1'b0;
    begin
      int t = 0;
      while (!done && t < 3000) begin @(negedge clk); t++; end
    end
    e = error;
    bp_en = 1'b0;
    begin
      logic [11:0] ea [8] = '{12'h005, 12'h007, 12'h009, 12'h020, 12'hFFF, 12'h004, 12'h100, 12'h101};
      logic [31:0] ed [8] = '{32'h7, 32'h9, 32'hAAAA, 32'hBBBB, 32'h5, 32'h1, 32'hCCCC, 32'h2};
      chk(scount == 8, "R10 R7 send count (exit slot runs, next does not)", scount, 8);
      for (int i = 0; i < 8; i++) begin
        chk(s_addr[i] == ea[i], $sformatf("R8 send %0d address", i), {20'b0, s_addr[i]}, {20'b0, ea[i]});
        chk(s_data[i] == ed[i], $sformatf("R7 send %0d data", i), s_data[i], ed[i]);
      end
    end
    chk(!e, "R12 all parameters consumed", {31'b0, e}, 32'd0);

    // R9 R10 R3 branches and exit
    clear_mem();
    imem[512] = enc(3'd1, 3'd1, 1'b0, 3'd1, 3'd1, 18'h3FFFF);
    imem[513] = enc(3'd7, 3'b001, 1'b0, 3'd0, 3'd1, 18'h3FFFF);
    imem[514] = enc(3'd1, 3'd4, 1'b0, 3'd0, 3'd1, 18'd0);
    imem[515] = enc(3'd7, 3'b010, 1'b0, 3'd0, 3'd0, 18'd2);
    imem[516] = enc(3'd1, 3'd4, 1'b0, 3'd0, 3'd0, 18'h77);
    imem[517] = enc(3'd1, 3'd1, 1'b0, 3'd0, 3'd0, 18'd9);
    imem[518] = enc(3'd1, 3'd4, 1'b1, 3'd0, 3'd0, 18'h55);
    imem[519] = enc(3'd1, 3'd4, 1'b1, 3'd0, 3'd0, 18'h66);
    imem[520] = enc(3'd1, 3'd4, 1'b0, 3'd0, 3'd0, 18'h88);
    pq[0] = 32'd3; pcount = 1;
    run_prog(10'd512, e);
    begin
      logic [31:0] ed [5] = '{32'd2, 32'd1, 32'd0, 32'h55, 32'h66};
      chk(scount == 5, "R9 R10 branch program send count", scount, 5);
      for (int i = 0; i < 5; i++)
        chk(s_data[i] == ed[i], $sformatf("R9 R3 R10 branch send %0d", i), s_data[i], ed[i]);
    end
    chk(!e, "R12 clean branch run", {31'b0, e}, 32'd0);

    // R4 carry chain
    clear_mem();
    imem[768] = enc(3'd1, 3'd0, 1'b0, 3'd2, 3'd0, 18'd0);
    imem[769] = enc(3'd0, 3'd1, 1'b0, 3'd3, 3'd1, alu_up(5'd0, 3'd2));
    imem[770] = enc(3'd0, 3'd4, 1'b0, 3'd0, 3'd0, alu_up(5'd1, 3'd0));
    imem[771] = enc(3'd0, 3'd1, 1'b0, 3'd3, 3'd2, alu_up(5'd2, 3'd1));
    imem[772] = enc(3'd0, 3'd4, 1'b0, 3'd0, 3'd0, alu_up(5'd3, 3'd0));
    imem[773] = enc(3'd0, 3'd1, 1'b0, 3'd3, 3'd1, alu_up(5'd2, 3'd2));
    imem[774] = enc(3'd0, 3'd4, 1'b1, 3'd0, 3'd0, alu_up(5'd3, 3'd0));
    pq[0] = 32'hFFFF_FFFF; pq[1] = 32'd1; pcount = 2;
    run_prog(10'd768, e);
    chk(scount == 3 && s_data[0] == 32'd1, "R4 add carry into adc", s_data[0], 32'd1);
    chk(s_data[1] == 32'hFFFF_FFFF, "R4 borrow into sbb", s_data[1], 32'hFFFF_FFFF);
    chk(s_data[2] == 32'd0, "R4 no borrow into sbb", s_data[2], 32'd0);

    // R12 error causes
    clear_mem();
    imem[100] = enc(3'd6, 3'd0, 1'b0, 3'd0, 3'd0, 18'd0);
    pq[0] = 32'd1; pcount = 1;
    run_prog(10'd100, e);
    chk(e && scount == 0, "R12 illegal operation", {31'b0, e}, 32'd1);
    @(negedge clk);
    chk(error, "R12 error stays set", {31'b0, error}, 32'd1);

    imem[100] = enc(3'd7, 3'b000, 1'b0, 3'd0, 3'd0, 18'd5);
    imem[101] = enc(3'd7, 3'b000, 1'b0, 3'd0, 3'd0, 18'd5);
    imem[102] = enc(3'd1, 3'd4, 1'b0, 3'd0, 3'd0, 18'd1);
    run_prog(10'd100, e);
    chk(e && scount == 0, "R12 branch in delay slot", {31'b0, e}, 32'd1);

    imem[100] = enc(3'd1, 3'd1, 1'b1, 3'd0, 3'd0, 18'd0);
    imem[101] = enc(3'd1, 3'd1, 1'b0, 3'd0, 3'd0, 18'd0);
    pq[0] = 32'd1; pq[1] = 32'd2; pcount = 2;
    run_prog(10'd100, e);
    chk(e, "R12 leftover parameter", {31'b0, e}, 32'd1);

    // R2 error clears on new start
    pcount = 1;
    run_prog(10'd100, e);
    chk(!e, "R2 error cleared by start", {31'b0, e}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule